// File: doc/BRIEF.md
# Paced Serial-In Shift Register

This block is an 8-bit serial-to-parallel shift register whose shifting is throttled by an internal modulo-5 pacing counter. Data arrives one bit at a time on a single serial input. Only one bit is accepted in every five clock cycles. On the accepting edge the new bit is written into the most significant position and the older bits move one place toward bit 0.

The full register contents are always visible on a parallel output. A synchronous, active-high reset clears the register and restarts the pacing counter. A system can therefore line up the capture points with its own slow data stream simply by releasing reset at a known cycle. The serial input is ignored on the four edges between accepting edges.

Top module: `paced_shift_reg`

## Requirements
- R1: The parallel output `par_out` is 8 bits wide and always shows the current register contents.
- R2: When `rst` is 1 at a rising clock edge, the register becomes all zeros and the pacing count restarts from zero on that edge.
- R3: On an accepting edge, `par_out[7]` takes the value of `ser_in`, each `par_out[i]` for i below 7 takes the former `par_out[i+1]`, and the former `par_out[0]` is lost.
- R4: On every rising edge that is neither a reset edge nor an accepting edge, `par_out` keeps its value.
- R5: `ser_in` is sampled only on accepting edges; its value on the other four edges of each period has no effect on `par_out`.
- R6: The first accepting edge is the fifth rising edge after the last reset edge. Each later accepting edge falls exactly five rising edges after the previous one.
- R7: A reset that arrives part-way through a pacing period discards the partial count, so the next accepting edge again comes five edges after that reset.
- R8: Forty edges after reset (eight accepting edges), `par_out[0]` holds the first bit that was sampled and `par_out[7]` holds the eighth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data, sampled on accepting edges only |
| par_out | output | 8 | Parallel view of the register, bit 7 is the newest bit |

## Verification
A pacing count that slips, sticks or wraps late moves the accepting edge. The first symptom is a `par_out` change one edge early or late relative to the reference model, and with a one-hot `ser_in` pattern this shows within the first five-edge period after reset. A broken shift path or a wrong insertion end shows as a misplaced bit on the very next accepting edge. A register that leaks `ser_in` between accepting edges shows as a change on a hold edge. The reference model compares every cycle, so each of these faults is reported within one clock of the first affected edge.

// File: rtl/paced_shift_pkg.sv
package paced_shift_pkg;

    localparam int unsigned DEF_WIDTH = 8;
    localparam int unsigned DEF_PACE  = 5;

    // Action applied to the register on a given edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_CLEAR = 2'd2
    } reg_act_e;

    // Control bundle from the pacing counter to the register.
    typedef struct packed {
        logic clear;
        logic take;
    } pace_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned pace);
        return (pace > 1) ? $clog2(pace) : 1;
    endfunction

    function automatic reg_act_e pick_act(input pace_ctl_t ctl);
        if (ctl.clear)
            return ACT_CLEAR;
        else if (ctl.take)
            return ACT_SHIFT;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/pace_counter.sv
module pace_counter
    import paced_shift_pkg::*;
#(
    parameter int unsigned PACE = DEF_PACE,
    localparam int unsigned CW  = cnt_width(PACE)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] count,
    output logic          take
);

    localparam logic [CW-1:0] LAST = CW'(PACE - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    assign take  = (cnt_q == LAST);
    assign count = cnt_q;

    always_comb begin
        if (take)
            cnt_d = '0;
        else
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/shift_core.sv
module shift_core
    import paced_shift_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  reg_act_e         act,
    input  logic             din,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic src;
        if (i == WIDTH - 1) begin : g_top
            assign src = din;
        end else begin : g_mid
            assign src = q_r[i+1];
        end

        always_comb begin
            unique case (act)
                ACT_CLEAR: q_d[i] = 1'b0;
                ACT_SHIFT: q_d[i] = src;
                default:   q_d[i] = q_r[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        q_r <= q_d;
    end

    assign q = q_r;

endmodule

// File: rtl/paced_shift_reg.sv
module paced_shift_reg
    import paced_shift_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned PACE  = DEF_PACE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_out
);

    localparam int unsigned CW = cnt_width(PACE);

    logic [CW-1:0] pace_cnt;
    logic          shift_en;
    pace_ctl_t     ctl;
    reg_act_e      act;

    pace_counter #(.PACE(PACE)) u_pace (
        .clk   (clk),
        .rst   (rst),
        .count (pace_cnt),
        .take  (shift_en)
    );

    always_comb begin
        ctl.clear = rst;
        ctl.take  = shift_en;
        act       = pick_act(ctl);
    end

    shift_core #(.WIDTH(WIDTH)) u_core (
        .clk (clk),
        .act (act),
        .din (ser_in),
        .q   (par_out)
    );

endmodule

// File: rtl/paced_shift_reg_chk.sv
module paced_shift_reg_chk
    import paced_shift_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned PACE  = DEF_PACE,
    localparam int unsigned CW   = cnt_width(PACE)
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_out,
    input logic             shift_en,
    input logic [CW-1:0]    pace_cnt
);

    // R2: reset edge empties the register
    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (par_out == '0));

    // R2, R7: reset edge restarts the pacing count
    a_r7_reset_restarts: assert property (@(posedge clk)
        rst |=> (pace_cnt == '0));

    // R3: accepting edge inserts at the top and moves bits down
    a_r3_shift_path: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (par_out[WIDTH-1] == $past(ser_in)) &&
                     (par_out[WIDTH-2:0] == $past(par_out[WIDTH-1:1])));

    // R4, R5: non-accepting edges leave the register alone
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(par_out));

    // R6: count advances by one between accepting edges
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> (int'(pace_cnt) == int'($past(pace_cnt)) + 1));

    // R6: count wraps to zero after an accepting edge
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (pace_cnt == '0));

    // R6: count never leaves its range
    a_r6_range: assert property (@(posedge clk) disable iff (rst)
        int'(pace_cnt) < int'(PACE));

endmodule

bind paced_shift_reg paced_shift_reg_chk #(.WIDTH(WIDTH), .PACE(PACE)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .par_out  (par_out),
    .shift_en (shift_en),
    .pace_cnt (pace_cnt)
);

// File: tb/paced_shift_reg_tb_top.sv
module paced_shift_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic [7:0] par_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    bit   mq[$];
    int   mcnt = 0;
    bit   taken[$];
    string last_tag = "R2";

    always #5 clk = ~clk;

    paced_shift_reg dut_i (
        .clk     (clk),
        .rst     (rst),
        .ser_in  (ser_in),
        .par_out (par_out)
    );

    function automatic logic [7:0] model_vec();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[7-i] = mq[i];
        return v;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: par_out=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, let the edge happen, update model, compare on falling edge
    task automatic tick(input logic r, input logic d);
        rst    = r;
        ser_in = d;
        @(posedge clk);
        if (r) begin
            mq.delete();
            for (int i = 0; i < 8; i++) mq.push_back(1'b0);
            mcnt = 0;
            taken.delete();
            last_tag = "R2";
        end else if (mcnt == 4) begin
            mq.push_front(d);
            void'(mq.pop_back());
            taken.push_back(d);
            mcnt = 0;
            last_tag = "R3";
        end else begin
            mcnt++;
            last_tag = "R4/R5";
        end
        @(negedge clk);
        check(last_tag, par_out, model_vec());
    endtask

    initial begin
        logic [7:0] exp8;
        logic [7:0] lfsr;
        lfsr = 8'hA7;

        // R2: reset state
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b0);
        check("R2 reset", par_out, 8'h00);

        // R6, R5: ser_in high on four hold edges, low on the fifth
        for (int e = 1; e <= 4; e++) tick(1'b0, 1'b1);
        check("R5 ignored between", par_out, 8'h00);
        tick(1'b0, 1'b0);
        check("R6 first take low", par_out, 8'h00);
        for (int e = 1; e <= 4; e++) tick(1'b0, 1'b0);
        check("R4 hold", par_out, 8'h00);
        tick(1'b0, 1'b1);
        check("R6 second take", par_out, 8'h80);
        for (int e = 1; e <= 4; e++) tick(1'b0, ~ser_in);
        check("R5 toggles ignored", par_out, 8'h80);

        // R7: reset after two edges of a period
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        tick(1'b1, 1'b1);
        check("R7 mid reset", par_out, 8'h00);
        for (int e = 1; e <= 4; e++) tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        check("R7 take after restart", par_out, 8'h80);

        // R1, R3, R8: forty edges of a pseudo-random stream
        tick(1'b1, 1'b0);
        for (int e = 1; e <= 40; e++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tick(1'b0, lfsr[0]);
        end
        for (int i = 0; i < 8; i++) exp8[i] = (taken.size() == 8) ? taken[i] : 1'b0;
        check("R8 eight samples", par_out, exp8);
        check("R1 width", 8'(taken.size()), 8'd8);

        // R3: walking one through all positions
        tick(1'b1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            for (int e = 1; e <= 5; e++) tick(1'b0, (k == 0 && e == 5));
            check("R3 walking one", par_out, 8'h80 >> k);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule